// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a small nonvolatile memory model reached over a three-wire serial link: a chip select, a serial clock and a data input, plus one data output with a separate output enable for the tri-state driver. It holds 1 kbit of storage. A width input chooses 64 words of 16 bits or 128 words of 8 bits. The serial pins are sampled in the system clock domain, and a rising serial clock is found by comparing each sample with the one before.

A frame is a start bit, a two-bit command, an address and, for write commands, a data field. The block decodes seven commands: read, single write, single erase, enable writes, disable writes, write all and erase all. Reads stream words out MSB first. A burst moves on through the address space for as long as the serial clock keeps running. Modifying commands pass, as a one-cycle request, to an internal program controller. That controller updates the register array over a fixed number of clock cycles and reports busy. While the link is selected and idle, the host polls the ready/busy status on the data output.

Top module: `mwire_eeprom`

## Requirements
- R1: After reset the data output enable is low and the write-enable latch is clear. A write sent before any enable command leaves the memory unchanged: every location reads all ones after reset.
- R2: With `org` high, addresses are 6 bits and words are 16 bits. With `org` low, addresses are 7 bits and words are 8 bits. In 8-bit mode, an odd byte address holds the upper half of the 16-bit word at that address divided by two, and an even byte address holds the lower half.
- R3: A frame is a 1 start bit, then a 2-bit command, then the address, MSB first. Command 10 is read. At the clock rise of the last address bit, the output turns on and drives a 0. Each later rise drives the next bit of the addressed word, MSB first.
- R4: While select stays high and the clock keeps running, a read continues with the next address and no extra 0 bit. After the highest address it wraps to 0.
- R5: Command 00 uses the two top address bits as a sub-code: 11 sets the write-enable latch, 00 clears it, 10 erases all, 01 writes all. Single write, single erase, write-all and erase-all change nothing while the latch is clear, and they start no status output.
- R6: Command 01 followed by a data word stores that word at the address.
- R7: Command 11 sets the addressed word to all ones.
- R8: Write-all stores its data in every location. In 8-bit mode the byte fills both halves of every word. Erase-all sets every location to all ones.
- R9: A modifying command starts only if select falls after its last bit and before the next clock rise. One extra clock rise before select falls discards the command.
- R10: Select going low part way through a frame abandons that frame. Zeros clocked in while waiting for a start bit are ignored.
- R11: Once a program request is issued, the output turns on whenever select is high and the link is idle. It drives 0 while programming runs and 1 when done. Start bits clocked in while busy are ignored. A start bit clocked in when ready turns the status off.
- R12: The output enable is low whenever select is low, and low while a frame is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled by `clk` |
| di | input | 1 | Serial data in, taken on a rising `sk` |
| org | input | 1 | Word width: 1 = 16-bit words, 0 = 8-bit words |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for the data-out driver |

## Verification
A wrong frame counter or a wrong command decode shows up on the next read. That read either returns the wrong word, or the 0 bit that comes before the data lands on the wrong clock rise. This is visible within one frame of the mistake. A stuck write-enable latch, or a request issued outside its window, leaves a location unexpectedly changed or unchanged, and the status output turns on, or fails to, as soon as select is raised again. A wrong burst increment or wraparound corrupts the second word of a two-word read that crosses the top address.

// File: rtl/mwire_pkg.sv
package mwire_pkg;

  typedef enum logic [1:0] {
    PG_WRITE,
    PG_ERASE,
    PG_WRALL,
    PG_ERALL
  } prog_op_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_OPC,
    FS_ADDR,
    FS_DATA,
    FS_PEND,
    FS_READ,
    FS_SKIP
  } fe_state_e;

  localparam logic [1:0] CMD_READ    = 2'b10;
  localparam logic [1:0] CMD_ERASE   = 2'b11;
  localparam logic [1:0] CMD_WRITE   = 2'b01;
  localparam logic [1:0] CMD_SPECIAL = 2'b00;

  localparam logic [1:0] SUB_WEN   = 2'b11;
  localparam logic [1:0] SUB_WDIS  = 2'b00;
  localparam logic [1:0] SUB_ERALL = 2'b10;
  localparam logic [1:0] SUB_WRALL = 2'b01;

endpackage

// File: rtl/mwire_array.sv
module mwire_array #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  localparam int AW     = $clog2(WORDS),
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        be,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [WORDS];
    logic [BYTE_W-1:0] rd_lane;

    initial begin
      for (int i = 0; i < WORDS; i++) mem[i] = '1;
    end

    always_ff @(posedge clk) begin
      if (we && be[g]) mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
      rd_lane <= mem[raddr];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = rd_lane;
  end

  AST_BE_VALID: assert property (@(posedge clk) disable iff (rst)
    we |-> (be != 2'b00)); // R2

endmodule

// File: rtl/mwire_prog.sv
module mwire_prog
  import mwire_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WORDS       = 64,
  parameter int PROG_CYCLES = 80,
  localparam int AW     = $clog2(WORDS),
  localparam int BYTE_W = WORD_W / 2,
  localparam int CW     = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  prog_op_e          req_op,
  input  logic [AW:0]       req_addr,
  input  logic [WORD_W-1:0] req_data,
  input  logic              org,
  output logic              busy,
  output logic              we,
  output logic [1:0]        be,
  output logic [AW-1:0]     waddr,
  output logic [WORD_W-1:0] wdata
);

  localparam logic [CW-1:0] LAST_CNT = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] SWEEP_N  = CW'(WORDS);

  prog_op_e          op_q;
  logic [AW:0]       addr_q;
  logic [WORD_W-1:0] data_q;
  logic              org_q;
  logic [CW-1:0]     cnt;
  logic              sweep;
  logic              clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_q   <= PG_WRITE;
      addr_q <= '0;
      data_q <= '0;
      org_q  <= 1'b1;
    end else if (req && !busy) begin
      busy   <= 1'b1;
      cnt    <= '0;
      op_q   <= req_op;
      addr_q <= req_addr;
      data_q <= req_data;
      org_q  <= org;
    end else if (busy) begin
      if (cnt == LAST_CNT) busy <= 1'b0;
      else                 cnt  <= cnt + 1'b1;
    end
  end

  always_comb begin
    sweep = (op_q == PG_WRALL) || (op_q == PG_ERALL);
    clear = (op_q == PG_ERASE) || (op_q == PG_ERALL);
    we    = busy && (sweep ? (cnt < SWEEP_N) : (cnt == '0));
    if (sweep)      waddr = cnt[AW-1:0];
    else if (org_q) waddr = addr_q[AW-1:0];
    else            waddr = addr_q[AW:1];
    if (sweep || org_q) be = 2'b11;
    else                be = addr_q[0] ? 2'b10 : 2'b01;
    if (clear)      wdata = '1;
    else if (org_q) wdata = data_q;
    else            wdata = {2{data_q[BYTE_W-1:0]}};
  end

  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    req |-> !busy); // R11

  AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> busy); // R11

endmodule

// File: rtl/mwire_front.sv
module mwire_front
  import mwire_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  localparam int AW     = $clog2(WORDS),
  localparam int BYTE_W = WORD_W / 2,
  localparam int CW     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  input  logic              org,
  input  logic              busy,
  output logic [AW:0]       rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              do_o,
  output logic              do_oe,
  output logic              req,
  output prog_op_e          req_op,
  output logic [AW:0]       req_addr,
  output logic [WORD_W-1:0] req_data
);

  localparam logic [CW-1:0] AL16 = CW'(AW - 1);
  localparam logic [CW-1:0] AL8  = CW'(AW);
  localparam logic [CW-1:0] DL16 = CW'(WORD_W - 1);
  localparam logic [CW-1:0] DL8  = CW'(BYTE_W - 1);
  localparam logic [AW:0]   MASK16 = {1'b0, {AW{1'b1}}};
  localparam logic [AW:0]   MASK8  = '1;

  fe_state_e         st;
  logic              sk_q;
  logic              rise;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     bits_left;
  logic [1:0]        cmd_q;
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] nxt;
  logic [WORD_W-1:0] osr;
  logic [WORD_W-1:0] cur_word;
  logic [AW:0]       addr_q;
  logic [AW:0]       a_full;
  logic [1:0]        sub;
  logic [WORD_W-1:0] data_q;
  prog_op_e          pend_op;
  logic              wen_q;
  logic              stat_q;
  logic              rsel_q;
  logic [CW-1:0]     addr_last;
  logic [CW-1:0]     data_last;
  logic [AW:0]       amask;

  always_comb begin
    rise      = sk && !sk_q;
    nxt       = {sr[WORD_W-2:0], di};
    addr_last = org ? AL16 : AL8;
    data_last = org ? DL16 : DL8;
    amask     = org ? MASK16 : MASK8;
    a_full    = org ? {1'b0, nxt[AW-1:0]} : nxt[AW:0];
    sub       = org ? nxt[AW-1:AW-2] : nxt[AW:AW-1];
    if (org) cur_word = rd_data;
    else     cur_word = {(rsel_q ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0]),
                         {BYTE_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FS_IDLE;
      sk_q      <= 1'b0;
      cnt       <= '0;
      bits_left <= '0;
      cmd_q     <= '0;
      sr        <= '0;
      osr       <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      pend_op   <= PG_WRITE;
      wen_q     <= 1'b0;
      stat_q    <= 1'b0;
      rsel_q    <= 1'b0;
      rd_addr   <= '0;
      do_o      <= 1'b0;
      do_oe     <= 1'b0;
      req       <= 1'b0;
      req_op    <= PG_WRITE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      sk_q   <= sk;
      rsel_q <= rd_addr[0];
      req    <= 1'b0;
      if (!cs) begin
        if (st == FS_PEND) begin
          req      <= 1'b1;
          req_op   <= pend_op;
          req_addr <= addr_q;
          req_data <= data_q;
          stat_q   <= 1'b1;
        end
        st    <= FS_IDLE;
        do_oe <= 1'b0;
      end else begin
        case (st)
          FS_IDLE: begin
            if (rise && di && !busy) begin
              st     <= FS_OPC;
              cnt    <= CW'(1);
              stat_q <= 1'b0;
              do_oe  <= 1'b0;
            end else begin
              do_oe <= stat_q;
              do_o  <= !busy;
            end
          end
          FS_OPC: if (rise) begin
            cmd_q <= {cmd_q[0], di};
            if (cnt == '0) begin
              st  <= FS_ADDR;
              cnt <= addr_last;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          FS_ADDR: if (rise) begin
            sr <= nxt;
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else begin
              addr_q <= a_full;
              case (cmd_q)
                CMD_READ: begin
                  st        <= FS_READ;
                  rd_addr   <= a_full;
                  bits_left <= '0;
                  do_oe     <= 1'b1;
                  do_o      <= 1'b0;
                end
                CMD_WRITE: begin
                  st      <= FS_DATA;
                  cnt     <= data_last;
                  pend_op <= PG_WRITE;
                end
                CMD_ERASE: begin
                  st      <= wen_q ? FS_PEND : FS_SKIP;
                  pend_op <= PG_ERASE;
                end
                default: begin
                  case (sub)
                    SUB_WEN: begin
                      wen_q <= 1'b1;
                      st    <= FS_SKIP;
                    end
                    SUB_WDIS: begin
                      wen_q <= 1'b0;
                      st    <= FS_SKIP;
                    end
                    SUB_ERALL: begin
                      st      <= wen_q ? FS_PEND : FS_SKIP;
                      pend_op <= PG_ERALL;
                    end
                    default: begin
                      st      <= FS_DATA;
                      cnt     <= data_last;
                      pend_op <= PG_WRALL;
                    end
                  endcase
                end
              endcase
            end
          end
          FS_DATA: if (rise) begin
            sr <= nxt;
            if (cnt != '0) begin
              cnt <= cnt - 1'b1;
            end else begin
              data_q <= org ? nxt : {{BYTE_W{1'b0}}, nxt[BYTE_W-1:0]};
              st     <= wen_q ? FS_PEND : FS_SKIP;
            end
          end
          FS_PEND: if (rise) st <= FS_SKIP;
          FS_READ: if (rise) begin
            if (bits_left == '0) begin
              do_o      <= cur_word[WORD_W-1];
              osr       <= cur_word << 1;
              bits_left <= data_last;
              rd_addr   <= (rd_addr + 1'b1) & amask;
            end else begin
              do_o      <= osr[WORD_W-1];
              osr       <= osr << 1;
              bits_left <= bits_left - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_REQ_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
    req |-> wen_q); // R5

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req |=> !req); // R9

  AST_REQ_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(!cs)); // R9

  AST_DO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !do_oe); // R12

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (st == FS_READ) |-> do_oe); // R3

endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
  import mwire_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WORDS       = 64,
  parameter int PROG_CYCLES = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);

  localparam int AW = $clog2(WORDS);

  logic [AW:0]       rd_addr;
  logic [AW-1:0]     raddr;
  logic [WORD_W-1:0] rd_data;
  logic              req;
  prog_op_e          req_op;
  logic [AW:0]       req_addr;
  logic [WORD_W-1:0] req_data;
  logic              busy;
  logic              we;
  logic [1:0]        be;
  logic [AW-1:0]     waddr;
  logic [WORD_W-1:0] wdata;

  assign raddr = org ? rd_addr[AW-1:0] : rd_addr[AW:1];

  mwire_front #(.WORD_W(WORD_W), .WORDS(WORDS)) u_front (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org(org), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data), .do_o(do_o), .do_oe(do_oe),
    .req(req), .req_op(req_op), .req_addr(req_addr), .req_data(req_data)
  );

  mwire_prog #(.WORD_W(WORD_W), .WORDS(WORDS), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .org(org), .busy(busy), .we(we), .be(be),
    .waddr(waddr), .wdata(wdata)
  );

  mwire_array #(.WORD_W(WORD_W), .WORDS(WORDS)) u_array (
    .clk(clk), .rst(rst), .we(we), .be(be), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: tb/mwire_eeprom_bench.sv
module mwire_eeprom_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  mwire_eeprom u_mwire_eeprom (
    .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); di = b; sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic int aw(); return org ? 6 : 7; endfunction
  function automatic int dw(); return org ? 16 : 8; endfunction

  // cmd: 2-bit command, extra: clock rises added before deselect
  task automatic instr(input logic [1:0] cmd, input int addr, input logic [15:0] data,
                       input bit has_data, input int extra);
    cs_on();
    send({29'd0, 1'b1, cmd}, 3);
    send(addr, aw());
    if (has_data) send({16'd0, data}, dw());
    for (int i = 0; i < extra; i++) sbit(1'b0);
    cs_off();
  endtask

  task automatic special(input logic [1:0] sub, input logic [15:0] data, input bit has_data);
    instr(2'b00, int'(sub) << (aw() - 2), data, has_data, 0);
  endtask

  task automatic wait_ready(input string tag);
    int k;
    cs_on();
    k = 0;
    while (!(do_oe === 1'b1 && do_o === 1'b1) && k < 2000) begin
      @(negedge clk); k++;
    end
    chk(tag, (k < 2000), 1);
    cs_off();
  endtask

  task automatic rd(input int addr, input int nw, input int lead,
                    output logic [15:0] w0, output logic [15:0] w1);
    logic [15:0] acc;
    w0 = '0; w1 = '0;
    cs_on();
    send(0, lead);
    send(3'b110, 3);
    send(addr, aw());
    chk("R3 dummy zero", {30'd0, do_oe, do_o}, 32'd2);
    for (int w = 0; w < nw; w++) begin
      acc = '0;
      for (int b = 0; b < dw(); b++) begin
        sbit(1'b0);
        acc = {acc[14:0], do_o};
      end
      if (w == 0) w0 = acc; else w1 = acc;
    end
    cs_off();
    chk("R12 off after deselect", {31'd0, do_oe}, 0);
  endtask

  task automatic t_reset();
    logic [15:0] a, b;
    chk("R1 oe after reset", {31'd0, do_oe}, 0);
    instr(2'b01, 5, 16'h1234, 1, 0);
    cs_on(); repeat (3) @(negedge clk);
    chk("R5 no status when locked", {31'd0, do_oe}, 0);
    cs_off();
    rd(5, 1, 0, a, b);
    chk("R1 write before enable ignored", a, 16'hFFFF);
  endtask

  task automatic t_write_read();
    logic [15:0] a, b;
    special(2'b11, 0, 0);
    instr(2'b01, 3, 16'hA5C3, 1, 0);
    cs_on(); repeat (3) @(negedge clk);
    chk("R11 busy status", {30'd0, do_oe, do_o}, 32'd2);
    cs_off();
    wait_ready("R11 ready status");
    cs_on(); sbit(1'b1);
    chk("R11 start bit ends status", {31'd0, do_oe}, 0);
    sbit(1'b0);
    chk("R12 quiet while shifting", {31'd0, do_oe}, 0);
    cs_off();
    rd(3, 1, 0, a, b);
    chk("R6 write then read", a, 16'hA5C3);
  endtask

  task automatic t_seq();
    logic [15:0] a, b;
    instr(2'b01, 63, 16'h1111, 1, 0); wait_ready("R4 prep");
    instr(2'b01, 0, 16'h2222, 1, 0);  wait_ready("R4 prep");
    rd(63, 2, 0, a, b);
    chk("R4 first word", a, 16'h1111);
    chk("R4 wrap to zero", b, 16'h2222);
  endtask

  task automatic t_erase();
    logic [15:0] a, b;
    instr(2'b11, 3, 0, 0, 0); wait_ready("R7 ready");
    rd(3, 1, 0, a, b);
    chk("R7 erase one", a, 16'hFFFF);
  endtask

  task automatic t_x8();
    logic [15:0] a, b;
    org = 1'b0;
    instr(2'b01, 7, 16'h005A, 1, 0); wait_ready("R2 ready");
    rd(6, 2, 0, a, b);
    chk("R2 even byte", a, 16'h00FF);
    chk("R2 odd byte in burst", b, 16'h005A);
    org = 1'b1;
    rd(3, 1, 0, a, b);
    chk("R2 byte placement", a, 16'h5AFF);
  endtask

  task automatic t_window();
    logic [15:0] a, b;
    instr(2'b01, 10, 16'h0F0F, 1, 1);
    cs_on(); repeat (3) @(negedge clk);
    chk("R9 late deselect no status", {31'd0, do_oe}, 0);
    cs_off();
    rd(10, 1, 0, a, b);
    chk("R9 late deselect discarded", a, 16'hFFFF);
  endtask

  task automatic t_abort();
    logic [15:0] a, b;
    cs_on(); send(3'b101, 3); send(2'b11, 2); cs_off();
    rd(3, 1, 3, a, b);
    chk("R10 abort and leading zeros", a, 16'h5AFF);
  endtask

  task automatic t_all();
    logic [15:0] a, b;
    special(2'b01, 16'hBEEF, 1); wait_ready("R8 ready");
    rd(20, 1, 0, a, b);
    chk("R8 write all", a, 16'hBEEF);
    rd(63, 1, 0, a, b);
    chk("R8 write all top", a, 16'hBEEF);
    special(2'b10, 0, 0); wait_ready("R8 ready");
    rd(20, 1, 0, a, b);
    chk("R8 erase all", a, 16'hFFFF);
  endtask

  task automatic t_lock();
    logic [15:0] a, b;
    instr(2'b01, 21, 16'h0000, 1, 0); wait_ready("R5 prep");
    special(2'b00, 0, 0);
    instr(2'b11, 21, 0, 0, 0);
    special(2'b10, 0, 0);
    cs_on(); repeat (3) @(negedge clk);
    chk("R5 locked no status", {31'd0, do_oe}, 0);
    cs_off();
    rd(21, 1, 0, a, b);
    chk("R5 locked erase ignored", a, 16'h0000);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] a, b;
    special(2'b11, 0, 0);
    instr(2'b01, 30, 16'h1357, 1, 0);
    cs_on();
    send(3'b110, 3);
    chk("R11 start bit ignored while busy", {30'd0, do_oe, do_o}, 32'd2);
    cs_off();
    wait_ready("R11 ready");
    rd(30, 1, 0, a, b);
    chk("R11 write completed", a, 16'h1357);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_seq();
    t_erase();
    t_x8();
    t_window();
    t_abort();
    t_all();
    t_lock();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule